// File: doc/BRIEF.md
# Two-Wire Slave Command Front End

This block is the bus-facing half of a small register-controlled peripheral on a two-wire serial bus. It runs on a fast system clock and oversamples the bus clock and data lines through a short synchronizer. From the synchronized lines it recognizes start and stop conditions and receives bytes on rising SCL edges. It drives the data line low only through an open-drain enable. The first byte after any start must carry a fixed four-bit type code in its upper nibble and the value of four strap pins in its lower nibble. Only then does the slave acknowledge.

After the address comes an instruction byte, which is acknowledged and handed to the core with a one-cycle strobe. The core then chooses the direction of the rest of the transaction through a read-mode input, which is sampled at the end of the instruction acknowledge. In write direction every further byte is acknowledged and strobed out. In read direction the slave sends a byte made of two zero bits and six data bits from the core, MSB first, and keeps sending while the master acknowledges. The core raises a busy flag while its nonvolatile write runs. During that time the address is not acknowledged, so the master can poll with repeated starts until the slave answers.

Top module: `twowire_cmd_slave`

## Requirements
- R1: After reset the data-line drive enable is low and no strobe is active.
- R2: A stop (SDA rising while SCL is high) pulses stop_o for one cycle, releases SDA and returns the slave to idle.
- R3: An address byte is acknowledged only when bits 7..4 equal 0101 and bits 3..0 equal strap_i. On any mismatch the slave neither acknowledges nor strobes anything until the next start or stop.
- R4: When busy_i is high as the address byte completes, a matching address is not acknowledged. Once busy_i is low, the same address is acknowledged after a repeated start.
- R5: After an acknowledged address, the next byte is received MSB first on rising SCL and acknowledged. It appears on instr_o with a single-cycle instr_vld_o pulse.
- R6: In write direction (rd_mode_i low at the end of the instruction acknowledge), every following byte is acknowledged and presented on data_o with a single-cycle data_vld_o pulse.
- R7: In read direction (rd_mode_i high at the end of the instruction acknowledge), the slave pulses rd_load_o and transmits {2'b00, rd_data_i} MSB first, one bit per SCL pulse. It releases SDA for the ninth pulse.
- R8: An acknowledge from the master (SDA low on the ninth pulse) makes the slave load and send another byte. A not-acknowledge makes it release SDA until the next start or stop.
- R9: A start detected at any point abandons the transaction in progress, and the next byte is taken as an address.
- R10: The drive enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap_i | input | 4 | Pin-strapped low nibble of the slave address |
| busy_i | input | 1 | Core nonvolatile write in progress; withholds address acknowledge |
| rd_mode_i | input | 1 | Core selects read direction after the instruction byte |
| rd_data_i | input | DATA_W | Data the slave transmits in read direction |
| instr_o | output | 8 | Last received instruction byte |
| instr_vld_o | output | 1 | One-cycle strobe when instr_o is updated |
| data_o | output | 8 | Last received write data byte |
| data_vld_o | output | 1 | One-cycle strobe when data_o is updated |
| rd_load_o | output | 1 | One-cycle strobe when rd_data_i is captured for sending |
| stop_o | output | 1 | One-cycle strobe on a stop condition |

## Verification
Properties checked on every cycle are these. The drive enable moves only while SCL is low. The core strobes are single-cycle and mutually exclusive. A stop never coincides with the slave pulling SDA. The bench scenarios cover the behaviour that depends on byte content and ordering. That includes the address and type-code matching, the busy-based polling, and the write and read byte sequences with master acknowledge and not-acknowledge. It also covers recovery through a repeated start in the middle of an instruction byte. These outcomes are only visible as the bits the master sees on the wire and the captured strobe values.

// File: rtl/twowire_cmd_slave.sv
module twowire_cmd_slave #(
  parameter logic [3:0] TYPE_ID = 4'b0101,
  parameter int         SYNC_N  = 2,
  parameter int         DATA_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [3:0]        strap_i,
  input  logic              busy_i,
  input  logic              rd_mode_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [7:0]        instr_o,
  output logic              instr_vld_o,
  output logic [7:0]        data_o,
  output logic              data_vld_o,
  output logic              rd_load_o,
  output logic              stop_o
);
  localparam int BYTE_W = 8;
  localparam int PAD_W  = BYTE_W - DATA_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_INSTR, S_IACK,
    S_WR, S_WACK, S_RD, S_RACK, S_SKIP
  } st_t;

  logic [SYNC_N:0] scl_p, sda_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_N-1:0], scl_i};
      sda_p <= {sda_p[SYNC_N-1:0], sda_i};
    end

  wire scl_s = scl_p[SYNC_N-1];
  wire scl_d = scl_p[SYNC_N];
  wire sda_s = sda_p[SYNC_N-1];
  wire sda_d = sda_p[SYNC_N];
  wire rise  = scl_s & ~scl_d;
  wire fall  = ~scl_s & scl_d;
  wire start = scl_s & scl_d & sda_d & ~sda_s;
  wire stop  = scl_s & scl_d & ~sda_d & sda_s;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sr, tx;
  logic             mack;

  wire addr_hit = (sr == {TYPE_ID, strap_i});
  wire rx_st    = (st == S_ADDR) || (st == S_INSTR) || (st == S_WR);
  wire byte_end = fall && (cnt == LAST);

  assign sda_oe = (st == S_AACK) || (st == S_IACK) || (st == S_WACK) ||
                  ((st == S_RD) && !tx[7]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      sr          <= '0;
      tx          <= '0;
      mack        <= 1'b0;
      instr_o     <= '0;
      data_o      <= '0;
      instr_vld_o <= 1'b0;
      data_vld_o  <= 1'b0;
      rd_load_o   <= 1'b0;
      stop_o      <= 1'b0;
    end else begin
      instr_vld_o <= 1'b0;
      data_vld_o  <= 1'b0;
      rd_load_o   <= 1'b0;
      stop_o      <= 1'b0;
      if (start) begin
        st  <= S_ADDR;
        cnt <= '0;
      end else if (stop) begin
        st     <= S_IDLE;
        cnt    <= '0;
        stop_o <= 1'b1;
      end else if (rx_st && rise) begin
        sr  <= {sr[6:0], sda_s};
        cnt <= cnt + 1'b1;
      end else if (rx_st && byte_end) begin
        cnt <= '0;
        case (st)
          S_ADDR:  st <= (addr_hit && !busy_i) ? S_AACK : S_SKIP;
          S_INSTR: begin
            instr_o     <= sr;
            instr_vld_o <= 1'b1;
            st          <= S_IACK;
          end
          default: begin
            data_o     <= sr;
            data_vld_o <= 1'b1;
            st         <= S_WACK;
          end
        endcase
      end else begin
        case (st)
          S_AACK: if (fall) st <= S_INSTR;
          S_WACK: if (fall) st <= S_WR;
          S_IACK: if (fall) begin
            if (rd_mode_i) begin
              tx        <= {{PAD_W{1'b0}}, rd_data_i};
              rd_load_o <= 1'b1;
              st        <= S_RD;
            end else begin
              st <= S_WR;
            end
          end
          S_RD: begin
            if (rise) cnt <= cnt + 1'b1;
            else if (fall) begin
              if (cnt == LAST) begin
                cnt <= '0;
                st  <= S_RACK;
              end else begin
                tx <= {tx[6:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (rise) mack <= ~sda_s;
            else if (fall) begin
              if (mack) begin
                tx        <= {{PAD_W{1'b0}}, rd_data_i};
                rd_load_o <= 1'b1;
                st        <= S_RD;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/twowire_cmd_slave_chk.sv
module twowire_cmd_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic instr_vld_o,
  input logic data_vld_o,
  input logic rd_load_o,
  input logic stop_o
);
  // R10: drive enable moves only during SCL low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R5 / R6 / R7 / R2: core strobes never overlap
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({instr_vld_o, data_vld_o, rd_load_o, stop_o}));

  p_instr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld_o |=> !instr_vld_o);

  p_data_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld_o |=> !data_vld_o);

  p_rdload_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load_o |=> !rd_load_o);

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> !sda_oe);

  p_stop_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o);
endmodule

bind twowire_cmd_slave twowire_cmd_slave_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .instr_vld_o(instr_vld_o), .data_vld_o(data_vld_o),
  .rd_load_o(rd_load_o), .stop_o(stop_o)
);

// File: tb/test_twowire_cmd_slave.sv
module test_twowire_cmd_slave;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic [3:0] strap = 4'hA;
  logic busy = 1'b0, rd_mode = 1'b0;
  logic [5:0] rd_data = '0;
  logic sda_oe, instr_vld, data_vld, rd_load, stop_p;
  logic [7:0] instr, data;
  wire sda_line = m_sda & ~sda_oe;

  int n_tests = 0, n_fail = 0;
  int n_instr = 0, n_data = 0, n_load = 0, n_stop = 0;
  logic [7:0] last_instr = '0, last_data = '0;

  always #2.5 clk = ~clk;

  twowire_cmd_slave i_twowire_cmd_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .busy_i(busy), .rd_mode_i(rd_mode), .rd_data_i(rd_data),
    .instr_o(instr), .instr_vld_o(instr_vld), .data_o(data), .data_vld_o(data_vld),
    .rd_load_o(rd_load), .stop_o(stop_p)
  );

  always @(posedge clk) begin
    if (instr_vld) begin n_instr <= n_instr + 1; last_instr <= instr; end
    if (data_vld)  begin n_data  <= n_data + 1;  last_data  <= data;  end
    if (rd_load) n_load <= n_load + 1;
    if (stop_p)  n_stop <= n_stop + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bstart();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bstop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
  endtask

  task automatic wbit(input logic b);
    m_sda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic give_ack);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(~give_ack);
  endtask

  task automatic t_reset();
    chk("R1 oe", int'(sda_oe), 0);
    chk("R1 strobes", int'({instr_vld, data_vld, rd_load, stop_p}), 0);
  endtask

  task automatic t_write();
    logic a;
    int s0 = n_stop;
    rd_mode = 1'b0;
    bstart();
    wbyte(8'h5A, a); chk("R3 addr ack", int'(a), 1);
    wbyte(8'hA2, a); chk("R5 instr ack", int'(a), 1);
    chk("R5 instr value", int'(last_instr), 8'hA2);
    wbyte(8'h2B, a); chk("R6 data ack", int'(a), 1);
    chk("R6 data value", int'(last_data), 8'h2B);
    wbyte(8'hD4, a); chk("R6 second ack", int'(a), 1);
    chk("R6 second value", int'(last_data), 8'hD4);
    chk("R6 data count", n_data, 2);
    bstop();
    chk("R2 stop pulse", n_stop - s0, 1);
    chk("R2 released", int'(sda_oe), 0);
  endtask

  task automatic t_bad_addr(input logic [7:0] adr, input string req);
    logic a;
    int i0 = n_instr;
    bstart();
    wbyte(adr, a); chk(req, int'(a), 0);
    wbyte(8'h8C, a); chk({req, " follow nack"}, int'(a), 0);
    chk({req, " no instr"}, n_instr - i0, 0);
    bstop();
  endtask

  task automatic t_busy();
    logic a;
    busy = 1'b1;
    bstart();
    wbyte(8'h5A, a); chk("R4 busy nack", int'(a), 0);
    bstart();
    wbyte(8'h5A, a); chk("R4 busy nack again", int'(a), 0);
    busy = 1'b0;
    bstart();
    wbyte(8'h5A, a); chk("R4 ack after busy", int'(a), 1);
    bstop();
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] v;
    int l0 = n_load;
    rd_mode = 1'b1;
    rd_data = 6'h2D;
    bstart();
    wbyte(8'h5A, a); chk("R7 addr ack", int'(a), 1);
    wbyte(8'h9F, a); chk("R7 instr ack", int'(a), 1);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    chk("R7 read byte", int'(v), 8'h2D);
    rd_data = 6'h3F;
    wbit(1'b0);
    rbyte(v, 1'b0);
    chk("R8 read after ack", int'(v), 8'h3F);
    rbyte(v, 1'b0);
    chk("R8 released after nack", int'(v), 8'hFF);
    chk("R7 load count", n_load - l0, 2);
    bstop();
    rd_mode = 1'b0;
  endtask

  task automatic t_restart();
    logic a;
    int i0 = n_instr;
    bstart();
    wbyte(8'h5A, a);
    for (int i = 0; i < 4; i++) wbit(1'b1);
    bstart();
    wbyte(8'h5A, a); chk("R9 addr after restart", int'(a), 1);
    wbyte(8'h33, a); chk("R9 instr ack", int'(a), 1);
    chk("R9 one instr", n_instr - i0, 1);
    chk("R9 instr value", int'(last_instr), 8'h33);
    bstop();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write();
    t_bad_addr(8'h5B, "R3 strap mismatch");
    t_bad_addr(8'h6A, "R3 type mismatch");
    t_busy();
    t_read();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule